// File: doc/BRIEF.md
# Register Width Bridge Adapter

This block connects a requester that issues 32-bit register accesses to a peripheral register file. The register file can sit on a bus with one of three layouts, and a static mode input selects which one. In word mode each register offset goes through unchanged as one 32-bit transfer. In wide mode, where registers are spaced 64 bits apart, the offset is doubled and the access is still one 32-bit transfer. In half mode the bus is 16 bits wide. The offset is halved, and each access becomes one or two 16-bit beats, lower half first.

In half mode, the number of beats is set by two lists of register offsets, not by the access itself. One list is used for reads and the other for writes. A read from the read list fetches a second half-word at the next half-word address and places it in the upper half of the result. Any other half-mode read returns the lower half-word with the upper bits cleared. A write to the write list sends its upper half as a second beat. Any other half-mode write sends only the lower half. Both lists are parameters, and their defaults are set in the package.

Both sides use a valid/ready handshake. The requester side accepts one access at a time. It stays not-ready until every beat of that access has completed, and it returns read data with a one-cycle valid pulse.

Top module: `reg_width_bridge`

## Requirements
- R1: While and after reset, with no request pending, reqReady is 1, busValid is 0 and rspValid is 0.
- R2: With mode 1 (word) or mode 3 (treated as word), an access is one beat with busAddr equal to reqOffset, busHalf 0, the full 32-bit write data, and read data taken as all 32 bits of busRdata.
- R3: With mode 2 (wide), an access is one beat with busAddr equal to reqOffset shifted left by one (so busAddr bit 0 is 0) and busHalf 0. Offsets in the read list are not split in this mode.
- R4: With mode 0 (half), the first beat has busAddr equal to reqOffset shifted right by one and busHalf 1, and it carries the lower half-word.
- R5: In half mode, a read whose offset is in the read list (defaults 0x018, 0x01C, 0x020, 0x024) takes a second beat at the first beat's address plus 2. Bits 15:0 returned by that beat become bits 31:16 of the result.
- R6: In half mode, a read whose offset is not in the read list is one beat, and the result's bits 31:16 are 0 whatever busRdata[31:16] carries.
- R7: In half mode, a write whose offset is in the write list (defaults 0x008, 0x038, 0x03C, 0x040, 0x044) takes a second beat at address plus 2 that carries reqWdata[31:16].
- R8: In half mode, a write whose offset is not in the write list is one beat carrying only reqWdata[15:0]. This holds even for offsets that are in the read list.
- R9: From the cycle after acceptance until all beats of the access have completed, reqReady stays 0, and a request presented during that time is not accepted.
- R10: While busValid is 1 and busReady is 0, busValid, busAddr and busWdata hold steady.
- R11: rspValid is high for exactly one cycle after the last beat of a read and never after a write, with rspData holding the assembled result.
- R12: In half mode, write beats place their half-word on busWdata[15:0] with busWdata[31:16] equal to 0, and read beats use only busRdata[15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Static bus layout: 0 half, 1 word, 2 wide, 3 word |
| reqValid | input | 1 | Requester presents an access |
| reqReady | output | 1 | Bridge can accept an access |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqOffset | input | OFF_W | Register offset |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | One-cycle read-result strobe |
| rspData | output | DATA_W | Assembled read result |
| busValid | output | 1 | Downstream beat valid |
| busReady | input | 1 | Downstream beat accepted |
| busWrite | output | 1 | Beat direction, 1 for write |
| busHalf | output | 1 | Beat is a 16-bit transfer |
| busAddr | output | OFF_W+1 | Downstream byte address |
| busWdata | output | DATA_W | Downstream write data |
| busRdata | input | DATA_W | Downstream read data |

## Verification
Two activities can overlap here: a read result being delivered on rspValid, and the requester already holding the next access on reqValid. To provoke this, a second request is raised right after the first is accepted and its fields are overwritten while the first is still in flight. The bench then checks three things: the first result is built from the first access's latched offset, no beat of the second access appears before the first finishes, and the second access follows with its own addresses. The release of a stalled first beat and the issue of the second beat are also run with a slow downstream responder, and the merged data must not change.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

  localparam int OFF_W_DEF = 12;
  localparam int DATA_W_DEF = 32;
  localparam int NUM_RD_DEF = 4;
  localparam int NUM_WR_DEF = 5;

  // Offsets whose half-mode reads take two beats (response words).
  localparam logic [NUM_RD_DEF*OFF_W_DEF-1:0] RD_SPLIT_DEF =
    {12'h024, 12'h020, 12'h01C, 12'h018};

  // Offsets whose half-mode writes take two beats (argument, status, masks).
  localparam logic [NUM_WR_DEF*OFF_W_DEF-1:0] WR_SPLIT_DEF =
    {12'h044, 12'h040, 12'h03C, 12'h038, 12'h008};

  typedef enum logic [1:0] {
    BUS_HALF = 2'd0,
    BUS_WORD = 2'd1,
    BUS_WIDE = 2'd2,
    BUS_RSVD = 2'd3
  } busMode_t;

  typedef struct packed {
    logic load;
    logic capLo;
    logic capHi;
    logic beatHi;
  } rwbStrobe_t;

endpackage

// File: rtl/rwb_ctrl.sv
module rwb_ctrl
  import rwb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       twoBeat,
  input  logic       isWrite,
  input  logic       busReady,
  output logic       reqReady,
  output logic       busValid,
  output logic       rspValid,
  output rwbStrobe_t strobe
);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_DONE} state_t;
  state_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      S_IDLE: if (reqValid) stateNxt = S_LO;
      S_LO:   if (busReady) stateNxt = twoBeat ? S_HI : S_DONE;
      S_HI:   if (busReady) stateNxt = S_DONE;
      S_DONE: stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  assign reqReady      = (state == S_IDLE);
  assign busValid      = (state == S_LO) || (state == S_HI);
  assign rspValid      = (state == S_DONE) && !isWrite;
  assign strobe.load   = (state == S_IDLE) && reqValid;
  assign strobe.capLo  = (state == S_LO) && busReady;
  assign strobe.capHi  = (state == S_HI) && busReady;
  assign strobe.beatHi = (state == S_HI);

  // R11: the read result strobe never lasts two cycles
  a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R9: an accepted access is followed by a beat, not by another acceptance
  a_r9_beat_after_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> busValid && !reqReady);

endmodule

// File: rtl/rwb_datapath.sv
module rwb_datapath
  import rwb_pkg::*;
#(
  parameter int OFF_W = OFF_W_DEF,
  parameter int DATA_W = DATA_W_DEF,
  parameter int NUM_RD = NUM_RD_DEF,
  parameter int NUM_WR = NUM_WR_DEF,
  parameter logic [NUM_RD*OFF_W-1:0] RD_LIST = RD_SPLIT_DEF,
  parameter logic [NUM_WR*OFF_W-1:0] WR_LIST = WR_SPLIT_DEF,
  localparam int ADDR_W = OFF_W + 1,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  rwbStrobe_t        strobe,
  input  logic              reqWrite,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              twoBeat,
  output logic              isWrite,
  output logic              busHalf,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rspData
);

  logic [OFF_W-1:0]  offQ;
  logic [DATA_W-1:0] wdQ;
  logic              wrQ;
  logic [DATA_W-1:0] rspQ;
  logic [NUM_RD-1:0] rdHit;
  logic [NUM_WR-1:0] wrHit;
  logic              halfMode;
  logic [ADDR_W-1:0] halfBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offQ <= '0;
      wdQ  <= '0;
      wrQ  <= 1'b0;
    end else if (strobe.load) begin
      offQ <= reqOffset;
      wdQ  <= reqWdata;
      wrQ  <= reqWrite;
    end
  end

  for (genvar i = 0; i < NUM_RD; i++) begin : g_rdMatch
    assign rdHit[i] = (offQ == RD_LIST[i*OFF_W +: OFF_W]);
  end
  for (genvar j = 0; j < NUM_WR; j++) begin : g_wrMatch
    assign wrHit[j] = (offQ == WR_LIST[j*OFF_W +: OFF_W]);
  end

  assign halfMode = (mode == BUS_HALF);
  assign twoBeat  = halfMode && (wrQ ? |wrHit : |rdHit);
  assign isWrite  = wrQ;
  assign busHalf  = halfMode;
  assign halfBase = ADDR_W'(offQ >> 1);

  always_comb begin
    unique case (mode)
      BUS_HALF: busAddr = halfBase + (strobe.beatHi ? ADDR_W'(2) : ADDR_W'(0));
      BUS_WIDE: busAddr = {offQ, 1'b0};
      default:  busAddr = ADDR_W'(offQ);
    endcase
  end

  always_comb begin
    if (!halfMode)          busWdata = wdQ;
    else if (strobe.beatHi) busWdata = {{HALF_W{1'b0}}, wdQ[DATA_W-1:HALF_W]};
    else                    busWdata = {{HALF_W{1'b0}}, wdQ[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspQ <= '0;
    end else if (strobe.load) begin
      rspQ <= '0;
    end else if (strobe.capLo) begin
      rspQ <= halfMode ? {{HALF_W{1'b0}}, busRdata[HALF_W-1:0]} : busRdata;
    end else if (strobe.capHi) begin
      rspQ[DATA_W-1:HALF_W] <= busRdata[HALF_W-1:0];
    end
  end

  assign rspData = rspQ;

  // R5: the second beat lands two bytes above the first
  a_r5_second_addr: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.beatHi) |-> busAddr == $past(busAddr) + ADDR_W'(2));

  // R6: a half-mode first capture leaves the upper result half clear
  a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capLo && halfMode) |=> rspQ[DATA_W-1:HALF_W] == '0);

endmodule

// File: rtl/reg_width_bridge.sv
module reg_width_bridge
  import rwb_pkg::*;
#(
  parameter int OFF_W = OFF_W_DEF,
  parameter int DATA_W = DATA_W_DEF,
  parameter int NUM_RD = NUM_RD_DEF,
  parameter int NUM_WR = NUM_WR_DEF,
  parameter logic [NUM_RD*OFF_W-1:0] RD_LIST = RD_SPLIT_DEF,
  parameter logic [NUM_WR*OFF_W-1:0] WR_LIST = WR_SPLIT_DEF,
  localparam int ADDR_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              busValid,
  input  logic              busReady,
  output logic              busWrite,
  output logic              busHalf,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata
);

  rwbStrobe_t strobe;
  logic       twoBeat;
  logic       isWrite;

  rwb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .twoBeat  (twoBeat),
    .isWrite  (isWrite),
    .busReady (busReady),
    .reqReady (reqReady),
    .busValid (busValid),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  rwb_datapath #(
    .OFF_W   (OFF_W),
    .DATA_W  (DATA_W),
    .NUM_RD  (NUM_RD),
    .NUM_WR  (NUM_WR),
    .RD_LIST (RD_LIST),
    .WR_LIST (WR_LIST)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (mode),
    .strobe    (strobe),
    .reqWrite  (reqWrite),
    .reqOffset (reqOffset),
    .reqWdata  (reqWdata),
    .busRdata  (busRdata),
    .twoBeat   (twoBeat),
    .isWrite   (isWrite),
    .busHalf   (busHalf),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .rspData   (rspData)
  );

  assign busWrite = isWrite;

  // R10: a stalled beat keeps its address and data
  a_r10_hold_beat: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> busValid && $stable(busAddr) && $stable(busWdata));

  // R3: wide-mode beats are full width at even addresses
  a_r3_wide_even: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && mode == BUS_WIDE) |-> !busAddr[0] && !busHalf);

  // R12: half-mode write beats use only the low lanes
  a_r12_half_lane: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busHalf && busWrite) |-> busWdata[DATA_W-1:DATA_W/2] == '0);

  // R11: no result strobe for a write
  a_r11_rsp_read_only: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !busWrite);

endmodule

// File: tb/tb_reg_width_bridge.sv
module tb_reg_width_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int OFF_W = 12;
  localparam int ADDR_W = 13;

  typedef struct packed {
    logic [1:0]        md;
    logic              wr;
    logic [OFF_W-1:0]  off;
    logic [31:0]       wd;
    logic [1:0]        beats;
    logic [ADDR_W-1:0] a0;
    logic [3:0]        rq;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 12'h018, 32'h0,        2'd2, 13'h00C, 4'd5},  // R5
    '{2'd0, 1'b0, 12'h024, 32'h0,        2'd2, 13'h012, 4'd5},  // R5
    '{2'd0, 1'b0, 12'h030, 32'h0,        2'd1, 13'h018, 4'd6},  // R6
    '{2'd0, 1'b0, 12'h038, 32'h0,        2'd1, 13'h01C, 4'd6},  // R6 status read single
    '{2'd0, 1'b1, 12'h008, 32'h1234ABCD, 2'd2, 13'h004, 4'd7},  // R7
    '{2'd0, 1'b1, 12'h03C, 32'hDEADBEEF, 2'd2, 13'h01E, 4'd7},  // R7
    '{2'd0, 1'b1, 12'h044, 32'h0F0F55AA, 2'd2, 13'h022, 4'd7},  // R7
    '{2'd0, 1'b1, 12'h030, 32'h87654321, 2'd1, 13'h018, 4'd8},  // R8
    '{2'd0, 1'b1, 12'h01C, 32'hCAFEF00D, 2'd1, 13'h00E, 4'd8},  // R8
    '{2'd1, 1'b0, 12'h018, 32'h0,        2'd1, 13'h018, 4'd2},  // R2
    '{2'd1, 1'b1, 12'h044, 32'h13579BDF, 2'd1, 13'h044, 4'd2},  // R2
    '{2'd2, 1'b0, 12'h0F0, 32'h0,        2'd1, 13'h1E0, 4'd3},  // R3
    '{2'd2, 1'b1, 12'h018, 32'h2468ACE0, 2'd1, 13'h030, 4'd3},  // R3
    '{2'd3, 1'b0, 12'h030, 32'h0,        2'd1, 13'h030, 4'd2},  // R2 mode 3
    '{2'd2, 1'b0, 12'h024, 32'h0,        2'd1, 13'h048, 4'd3}   // R3 no split
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic reqWrite = 1'b0;
  logic [OFF_W-1:0] reqOffset = '0;
  logic [31:0] reqWdata = '0;
  logic rspValid;
  logic [31:0] rspData;
  logic busValid;
  logic busReady = 1'b0;
  logic busWrite;
  logic busHalf;
  logic [ADDR_W-1:0] busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata = '0;

  reg_width_bridge dut (
    .clk(clk), .rstN(rstN), .mode(mode),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData),
    .busValid(busValid), .busReady(busReady), .busWrite(busWrite),
    .busHalf(busHalf), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  int stallCyc = 0;
  int logN = 0;
  logic [ADDR_W-1:0] logA [8];
  logic [31:0] logW [8];
  logic logH [8];
  logic logWr [8];
  int rspCnt;
  logic [31:0] rspD;
  int badReady;
  bit finished = 0;

  function automatic logic [31:0] busModel(input logic [ADDR_W-1:0] a);
    logic [15:0] a16;
    a16 = 16'(a);
    return {a16 ^ 16'hC3C3, a16 ^ 16'h5A5A};
  endfunction

  function automatic logic [31:0] expRead(input logic [1:0] md, input logic [1:0] beats,
                                          input logic [ADDR_W-1:0] a0);
    logic [31:0] lo, hi;
    lo = busModel(a0);
    hi = busModel(a0 + ADDR_W'(2));
    if (md != 2'd0) return lo;
    if (beats == 2'd2) return {hi[15:0], lo[15:0]};
    return {16'h0, lo[15:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Downstream responder
  initial begin
    int waitCnt;
    waitCnt = 0;
    forever begin
      @(negedge clk);
      if (busReady) begin
        busReady = 1'b0;
        waitCnt = 0;
      end else if (busValid) begin
        if (waitCnt >= stallCyc) begin
          busReady = 1'b1;
          busRdata = busModel(busAddr);
          if (logN < 8) begin
            logA[logN] = busAddr;
            logW[logN] = busWdata;
            logH[logN] = busHalf;
            logWr[logN] = busWrite;
          end
          logN++;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic startReq(input logic [1:0] md, input logic wr,
                          input logic [OFF_W-1:0] off, input logic [31:0] wd);
    mode = md;
    reqWrite = wr;
    reqOffset = off;
    reqWdata = wd;
    reqValid = 1'b1;
  endtask

  task automatic waitAccept();
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    #1;
    reqValid = 1'b0;
  endtask

  task automatic waitDone();
    int lim;
    lim = 0;
    rspCnt = 0;
    badReady = 0;
    do begin
      @(negedge clk);
      if (rspValid) begin
        rspCnt++;
        rspD = rspData;
      end
      if (busValid && reqReady) badReady++;
      lim++;
    end while (!reqReady && lim < 200);
  endtask

  task automatic runVec(input vec_t v);
    string rs;
    logic [31:0] expLo, expHi;
    rs = $sformatf("R%0d", v.rq);
    logN = 0;
    @(negedge clk);
    startReq(v.md, v.wr, v.off, v.wd);
    waitAccept();
    waitDone();
    check(logN == int'(v.beats), rs, "beat count", 32'(logN), 32'(v.beats));
    check(logA[0] == v.a0, rs, "first address", 32'(logA[0]), 32'(v.a0));
    check(logH[0] == (v.md == 2'd0), rs, "half flag (R4)", 32'(logH[0]), 32'(v.md == 2'd0));
    check(logWr[0] == v.wr, rs, "beat direction", 32'(logWr[0]), 32'(v.wr));
    check(badReady == 0, "R9", "ready during beats", 32'(badReady), 32'd0);
    if (v.beats == 2'd2 && logN >= 2)
      check(logA[1] == v.a0 + ADDR_W'(2), rs, "second address",
            32'(logA[1]), 32'(v.a0 + ADDR_W'(2)));
    if (v.wr) begin
      expLo = (v.md == 2'd0) ? {16'h0, v.wd[15:0]} : v.wd;  // R12 lanes
      expHi = {16'h0, v.wd[31:16]};
      check(logW[0] == expLo, rs, "first write data", logW[0], expLo);
      if (v.beats == 2'd2 && logN >= 2)
        check(logW[1] == expHi, rs, "second write data", logW[1], expHi);
      check(rspCnt == 0, "R11", "strobe after write", 32'(rspCnt), 32'd0);
    end else begin
      check(rspCnt == 1, "R11", "strobe count", 32'(rspCnt), 32'd1);
      expLo = expRead(v.md, v.beats, v.a0);
      check(rspD == expLo, rs, "read result", rspD, expLo);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] expA;
    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1 && busValid == 1'b0 && rspValid == 1'b0, "R1",
          "outputs in reset", {29'h0, reqReady, busValid, rspValid}, 32'h4);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(reqReady == 1'b1 && busValid == 1'b0 && rspValid == 1'b0, "R1",
          "outputs after reset", {29'h0, reqReady, busValid, rspValid}, 32'h4);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);

    // R10: slow downstream, two-beat read and two-beat write
    stallCyc = 3;
    runVec(VECS[0]);
    runVec(VECS[5]);
    stallCyc = 0;

    // R9: next request raised while a two-beat read is in flight
    logN = 0;
    @(negedge clk);
    startReq(2'd0, 1'b0, 12'h020, 32'h0);
    waitAccept();
    startReq(2'd0, 1'b1, 12'h040, 32'h55AA33CC);
    waitDone();
    check(logN == 2, "R9", "beats before second accept", 32'(logN), 32'd2);
    expA = expRead(2'd0, 2'd2, 13'h010);
    check(rspCnt == 1 && rspD == expA, "R5", "first result under overlap", rspD, expA);
    waitAccept();
    waitDone();
    check(logN == 4, "R9", "total beats", 32'(logN), 32'd4);
    check(logA[2] == 13'h020 && logA[3] == 13'h022, "R7", "queued write addresses",
          {3'h0, logA[2], 3'h0, logA[3]}, {3'h0, 13'h020, 3'h0, 13'h022});
    check(logW[3] == 32'h0000_55AA, "R12", "queued upper half lane", logW[3], 32'h0000_55AA);
    check(rspCnt == 0, "R11", "no strobe after queued write", 32'(rspCnt), 32'd0);

    // R1: back to idle
    @(negedge clk);
    check(reqReady == 1'b1 && busValid == 1'b0, "R1", "idle after traffic",
          {30'h0, reqReady, busValid}, 32'h2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule